// File: doc/BRIEF.md
# Spread-Chip Despreader with Bit Decision

This block turns a stream of hard-sliced chips back into information bits. Each chip arrives with a valid qualifier. A start flag marks the first chip of every bit period. The block compares each chip with the matching chip of the two reference codes that belong to the chosen spreading length. It counts the matches over the whole group, then decides one bit and reports how strongly the two counts differ.

The spreading length is 1, 2, 4 or 8 chips per bit. It is picked at run time by a two-bit selector. The block samples that selector on the first chip of a group, so the group keeps its length until the group is complete. If a start flag arrives while a group is only partly received, the block drops the partial group, raises an error pulse and opens a new group with that chip. Chip timing recovery, frequency tracking, demodulation and error-correction decoding happen elsewhere.

Top module: `dsss_despreader`

## Requirements
- R1: `sf_sel` selects the group length. The encoding is 0 = 1 chip, 1 = 2 chips, 2 = 4 chips and 3 = 8 chips. Exactly one decision is made per complete group.
- R2: With length 1, the decided bit equals the received chip, the margin is 1 and the tie flag is 0.
- R3: With length 2, the reference code for a 1 bit is chips 1,1 and the code for a 0 bit is 0,0. Chips are listed in arrival order.
- R4: With length 4, the code for a 1 bit is 0,0,1,1 and the code for a 0 bit is 1,1,0,0. Chips are listed in arrival order.
- R5: With length 8, the code for a 1 bit is 0,0,1,1,0,0,1,1 and the code for a 0 bit is 1,1,0,0,1,1,0,0. Chips are listed in arrival order.
- R6: The decided bit is the code value that has more matching chips in the group.
- R7: `margin` equals the absolute difference between the match counts of the two codes.
- R8: When the two match counts are equal, `bit_out` is 0, `bit_tie` is 1 and `margin` is 0. In every other case `bit_tie` is 0.
- R9: A chip that carries `chip_first` while a group is partly received makes `grp_err` pulse for one cycle. The partial group is discarded, and that chip becomes chip 0 of a new group. `grp_err` is never raised otherwise.
- R10: `bit_vld` is high for exactly the one cycle after the clock edge that captures the last chip of a group. At all other times it is low.
- R11: The group length is taken from `sf_sel` at the chip that opens the group. A change of `sf_sel` in the middle of a group has no effect on that group.
- R12: While reset is held and after it is released, `bit_vld`, `grp_err`, `bit_out`, `bit_tie` and `margin` are all 0, and no group is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_sel | input | 2 | Spreading length selector (0:1, 1:2, 2:4, 3:8) |
| chip_in | input | 1 | Hard-sliced chip value |
| chip_vld | input | 1 | Chip qualifier |
| chip_first | input | 1 | Chip is the first of a bit period |
| bit_out | output | 1 | Decided bit |
| bit_vld | output | 1 | One-cycle strobe for a new decision |
| bit_tie | output | 1 | Match counts were equal |
| margin | output | 4 | Absolute difference of the match counts |
| grp_err | output | 1 | Partial group was dropped |

## Verification
A dropped group and a completed decision can be reported in the same cycle. This happens when a start flag cuts an 8-chip group short while `sf_sel` already selects length 1: the interrupting chip forms a complete one-chip group by itself. The bench provokes this case on purpose. It also produces it again through random start flags and random changes of the selector. Its behavioural model predicts both the error pulse and the one-chip decision for the same cycle, and every clock the outputs are compared with that prediction.

// File: rtl/dsss_despreader.sv
module dsss_despreader #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sf_sel,
  input  logic          chip_in,
  input  logic          chip_vld,
  input  logic          chip_first,
  output logic          bit_out,
  output logic          bit_vld,
  output logic          bit_tie,
  output logic [CW-1:0] margin,
  output logic          grp_err
);

  logic [2:0]    idx;
  logic [1:0]    sf_g;
  logic [CW-1:0] acc;

  wire           start  = chip_first || (idx == 3'd0);
  wire [1:0]     sf_cur = start ? sf_sel : sf_g;
  wire [CW-1:0]  len    = CW'(1) << sf_cur;
  wire [2:0]     pos    = start ? 3'd0 : idx;
  wire           ref1   = sf_cur[1] ? pos[1] : 1'b1;
  wire [CW-1:0]  a1     = (start ? CW'(0) : acc) + CW'(chip_in == ref1);
  wire [CW-1:0]  a0     = len - a1;
  wire           last   = (CW'(pos) + CW'(1)) == len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; sf_g <= '0; acc <= '0;
      bit_out <= 1'b0; bit_vld <= 1'b0; bit_tie <= 1'b0;
      margin <= '0; grp_err <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      grp_err <= 1'b0;
      if (chip_vld) begin
        grp_err <= chip_first && (idx != 3'd0);
        if (last) begin
          idx     <= '0;
          bit_vld <= 1'b1;
          bit_out <= a1 > a0;
          bit_tie <= a1 == a0;
          margin  <= (a1 > a0) ? a1 - a0 : a0 - a1;
        end else begin
          idx  <= pos + 3'd1;
          acc  <= a1;
          sf_g <= sf_cur;
        end
      end
    end
  end

  AST_TIE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && bit_tie |-> !bit_out && margin == '0); // R8
  AST_MARGIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && !bit_tie |-> margin != '0 && margin <= CW'(8)); // R7
  AST_NO_CHIP_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_vld |=> !bit_vld && !grp_err); // R10
  AST_ERR_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_vld && chip_first) |=> !grp_err); // R9
  AST_IDX_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    idx != 3'd0 |-> CW'(idx) < (CW'(1) << sf_g)); // R1

endmodule

// File: tb/test_dsss_despreader.sv
module test_dsss_despreader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sf_sel = 2'd0;
  logic chip_in = 1'b0, chip_vld = 1'b0, chip_first = 1'b0;
  logic bit_out, bit_vld, bit_tie, grp_err;
  logic [3:0] margin;

  always #4 clk = ~clk;

  dsss_despreader i_dsss_despreader (
    .clk(clk), .rst_n(rst_n), .sf_sel(sf_sel), .chip_in(chip_in),
    .chip_vld(chip_vld), .chip_first(chip_first), .bit_out(bit_out),
    .bit_vld(bit_vld), .bit_tie(bit_tie), .margin(margin), .grp_err(grp_err));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int q[$];
  int g_len = 1;
  int e_vld, e_bit, e_tie, e_mar, e_err;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string bit_tag(int l);
    case (l)
      1: return "R2";
      2: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic model(int c, int v, int f);
    e_vld = 0; e_err = 0;
    if (!v) return;
    if (f && q.size() > 0) begin e_err = 1; q.delete(); end
    if (q.size() == 0) g_len = 1 << sf_sel;
    q.push_back(c);
    if (q.size() == g_len) begin
      int m1 = 0, m0;
      foreach (q[k]) begin
        int r = (g_len >= 4) ? ((k >> 1) & 1) : 1;
        if (q[k] == r) m1++;
      end
      m0 = g_len - m1;
      e_vld = 1;
      e_bit = (m1 > m0);
      e_tie = (m1 == m0);
      e_mar = (m1 > m0) ? m1 - m0 : m0 - m1;
      q.delete();
    end
  endtask

  task automatic step(int c, int v, int f);
    @(negedge clk);
    chip_in = c[0]; chip_vld = v[0]; chip_first = f[0];
    model(c, v, f);
    @(posedge clk); #2;
    chk("R1/R10 bit_vld", bit_vld, e_vld);
    chk("R9 grp_err", grp_err, e_err);
    if (e_vld) begin
      chk({bit_tag(g_len), "/R6 bit_out"}, bit_out, e_bit);
      chk("R8 bit_tie", bit_tie, e_tie);
      chk("R7 margin", margin, e_mar);
    end
  endtask

  task automatic send(int sf, int pat, int len);
    sf_sel = sf[1:0];
    for (int k = 0; k < len; k++) step((pat >> (len - 1 - k)) & 1, 1, k == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    // R12 reset state
    chk("R12 bit_vld", bit_vld, 0); chk("R12 grp_err", grp_err, 0);
    chk("R12 bit_out", bit_out, 0); chk("R12 bit_tie", bit_tie, 0);
    chk("R12 margin", margin, 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0);
    // R2 single chip groups
    send(0, 1, 1); send(0, 0, 1); send(0, 1, 1);
    // R3 codes, one error gives a tie
    send(1, 'b11, 2); send(1, 'b00, 2); send(1, 'b10, 2);
    // R4 codes, one error, two errors (tie)
    send(2, 'b0011, 4); send(2, 'b1100, 4); send(2, 'b0111, 4);
    send(2, 'b1000, 4); send(2, 'b0101, 4);
    // R5 codes, errors, tie
    send(3, 'b00110011, 8); send(3, 'b11001100, 8);
    send(3, 'b10110010, 8); send(3, 'b00000000, 8); send(3, 'b11111111, 8);
    // R11: selector changes mid group without effect
    sf_sel = 2'd3; step(0, 1, 1); sf_sel = 2'd0;
    for (int k = 1; k < 8; k++) begin
      step(0, 0, 0);
      step(((k >> 1) & 1), 1, 0);
    end
    // R9 abort, and abort coinciding with a one-chip decision
    sf_sel = 2'd2; step(1, 1, 1); step(1, 1, 0);
    send(2, 'b0011, 4);
    sf_sel = 2'd3; step(0, 1, 1); step(0, 1, 0); step(1, 1, 0);
    sf_sel = 2'd0; step(1, 1, 1);
    // random stress
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 16) == 0) sf_sel = 2'($urandom);
      step($urandom % 2, ($urandom % 8) != 0, ($urandom % 12) == 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule